// File: doc/BRIEF.md
# Pulse-Counted Panel Number Display Driver

This block shows a number on a maintenance-panel counter that understands only two one-cycle commands. A clear command resets the counter to zero and an increment command adds one. When the block is idle and sees a start strobe, it captures the number on its value input. It first issues a single clear pulse. It then issues exactly that many increment pulses and raises a one-cycle done indication.

The panel needs time to settle after each command. The wait after a clear is longer than the wait after an increment. Both waits are given as times in picoseconds, together with the clock period. The block converts them into whole cycle counts, rounding up, so each wait is never shorter than the time asked for. The two commands are never raised in the same cycle.

The driver is meant for a controller that needs to show a short status or error code. Numbers above the meaningful range are clipped to its upper limit. While a display sequence is in progress, further start strobes are ignored.

Top module: `mpanel_count_drv`

## Requirements
- R1: During reset and while idle with no start strobe, clr_o, inc_o, done_o and busy_o are all low.
- R2: A start_i sampled high while busy_o is low gives exactly one clr_o pulse, one cycle wide, in the next cycle. busy_o goes high in that same cycle.
- R3: After the clear pulse, inc_o pulses exactly N times for a captured value N. No increment comes before the clear pulse or after done_o.
- R4: Let GC = ceil(CLR_GAP_PS / CLK_PS), with a minimum of 1. The command after a clear pulse comes exactly GC+1 cycles after the clear cycle, so at least GC full idle cycles separate them.
- R5: Let GI = ceil(STEP_GAP_PS / CLK_PS), with a minimum of 1. Each increment pulse is followed by the next command exactly GI+1 cycles later.
- R6: clr_o and inc_o are never high in the same cycle, and each pulse lasts one cycle.
- R7: done_o is high for exactly one cycle, GC+1+N*(GI+1) cycles after the clear cycle. busy_o is high until that cycle inclusive and low in the cycle after it.
- R8: A start_i strobe while busy_o is high (including the done cycle) has no effect. No extra clear is issued and the increment count follows the value captured first.
- R9: A value above MAX_VAL (9999 by default) is saturated, so MAX_VAL increments are issued.
- R10: A value of 0 produces a clear pulse, no increments, and done_o GC+1 cycles after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| value_i | input | VAL_W | Number to display, captured with the start strobe |
| clr_o | output | 1 | One-cycle clear command to the panel |
| inc_o | output | 1 | One-cycle increment command to the panel |
| busy_o | output | 1 | High from the clear cycle through the done cycle |
| done_o | output | 1 | One-cycle pulse marking the end of the sequence |

## Verification
The assertions check the following on every cycle:
- the two commands never overlap;
- each clear is caused by an accepted strobe;
- the minimum spacing holds after each kind of command;
- done lands exactly one settling gap after the last command and does not repeat;
- strobes during a busy sequence produce no clear.

Other behaviour can only be shown by the bench's scenarios. These are the exact number of increments for each value, the exact cycle position of every increment and of done, saturation of large values, and the zero case. The bench sweeps a contiguous range of values with short gaps, pokes extra strobes into some runs, and computes every expected position from the gap arithmetic.

// File: rtl/mpanel_pkg.sv
package mpanel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_STEP,
        ST_FINISH
    } seq_state_e;

    typedef enum logic {
        GAP_AFTER_CLEAR,
        GAP_AFTER_STEP
    } gap_kind_e;

    typedef struct packed {
        logic clear;
        logic step;
    } panel_cmd_t;

    // Whole cycles covering a time span, rounded up, never below one.
    function automatic int unsigned cycles_for(input int unsigned span_ps,
                                               input int unsigned clk_ps);
        int unsigned c;
        c = (span_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Bits needed to hold values 0..v.
    function automatic int unsigned width_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/mpanel_gap_timer.sv
module mpanel_gap_timer
    import mpanel_pkg::*;
#(
    parameter int unsigned CLR_CYC  = 80,
    parameter int unsigned STEP_CYC = 40
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      arm_i,
    input  gap_kind_e kind_i,
    output logic      last_o
);
    localparam int unsigned LONGEST = (CLR_CYC > STEP_CYC) ? CLR_CYC : STEP_CYC;
    localparam int unsigned CW      = width_for(LONGEST);

    logic [CW-1:0] cnt_q;

    // Arming loads the gap length; the count then runs down to zero.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (arm_i) begin
            cnt_q <= (kind_i == GAP_AFTER_CLEAR) ? CW'(CLR_CYC) : CW'(STEP_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/mpanel_step_counter.sv
module mpanel_step_counter #(
    parameter int unsigned VAL_W   = 14,
    parameter int unsigned MAX_VAL = 9999
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [VAL_W-1:0] value_i,
    input  logic             dec_i,
    output logic             zero_o
);
    localparam logic [VAL_W-1:0] CAP = VAL_W'(MAX_VAL);

    logic [VAL_W-1:0] rem_q;
    logic [VAL_W-1:0] capped;

    assign capped = (value_i > CAP) ? CAP : value_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= capped;
        end else if (dec_i && (rem_q != '0)) begin
            rem_q <= rem_q - VAL_W'(1);
        end
    end

    assign zero_o = (rem_q == '0);

endmodule

// File: rtl/mpanel_seq.sv
module mpanel_seq
    import mpanel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic       gap_last_i,
    input  logic       none_left_i,
    output panel_cmd_t cmd_o,
    output logic       load_o,
    output logic       arm_o,
    output gap_kind_e  kind_o,
    output logic       busy_o,
    output logic       done_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_SETTLE;
            ST_SETTLE: if (gap_last_i) state_d = none_left_i ? ST_FINISH : ST_STEP;
            ST_STEP:   state_d = ST_SETTLE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    assign load_o    = (state_q == ST_IDLE) && start_i;
    assign cmd_o.clear = (state_q == ST_CLEAR);
    assign cmd_o.step  = (state_q == ST_STEP);
    assign arm_o     = cmd_o.clear || cmd_o.step;
    assign kind_o    = cmd_o.step ? GAP_AFTER_STEP : GAP_AFTER_CLEAR;
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = (state_q == ST_FINISH);

endmodule

// File: rtl/mpanel_count_drv.sv
module mpanel_count_drv
    import mpanel_pkg::*;
#(
    parameter int unsigned CLK_PS      = 10000,
    parameter int unsigned CLR_GAP_PS  = 800000,
    parameter int unsigned STEP_GAP_PS = 400000,
    parameter int unsigned VAL_W       = 14,
    parameter int unsigned MAX_VAL     = 9999
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [VAL_W-1:0] value_i,
    output logic             clr_o,
    output logic             inc_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int unsigned CLR_CYC  = cycles_for(CLR_GAP_PS, CLK_PS);
    localparam int unsigned STEP_CYC = cycles_for(STEP_GAP_PS, CLK_PS);

    panel_cmd_t cmd;
    gap_kind_e  kind;
    logic       load, arm, gap_last, none_left;

    mpanel_seq seq_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .gap_last_i  (gap_last),
        .none_left_i (none_left),
        .cmd_o       (cmd),
        .load_o      (load),
        .arm_o       (arm),
        .kind_o      (kind),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    mpanel_gap_timer #(
        .CLR_CYC  (CLR_CYC),
        .STEP_CYC (STEP_CYC)
    ) timer_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .arm_i  (arm),
        .kind_i (kind),
        .last_o (gap_last)
    );

    mpanel_step_counter #(
        .VAL_W   (VAL_W),
        .MAX_VAL (MAX_VAL)
    ) steps_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load),
        .value_i (value_i),
        .dec_i   (cmd.step),
        .zero_o  (none_left)
    );

    assign clr_o = cmd.clear;
    assign inc_o = cmd.step;

endmodule

// File: rtl/mpanel_count_drv_chk.sv
module mpanel_count_drv_chk
    import mpanel_pkg::*;
#(
    parameter int unsigned CLK_PS      = 10000,
    parameter int unsigned CLR_GAP_PS  = 800000,
    parameter int unsigned STEP_GAP_PS = 400000
) (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic clr_o,
    input logic inc_o,
    input logic busy_o,
    input logic done_o
);
    localparam int unsigned CLR_CYC  = cycles_for(CLR_GAP_PS, CLK_PS);
    localparam int unsigned STEP_CYC = cycles_for(STEP_GAP_PS, CLK_PS);

    logic [15:0] since_q;
    logic        seen_q;
    logic        last_clr_q;
    logic [15:0] need;

    // Cycles since the most recent command, saturating.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_q    <= '0;
            seen_q     <= 1'b0;
            last_clr_q <= 1'b0;
        end else if (clr_o || inc_o) begin
            since_q    <= 16'd1;
            seen_q     <= 1'b1;
            last_clr_q <= clr_o;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    assign need = last_clr_q ? 16'(CLR_CYC) : 16'(STEP_CYC);

    p_clr_accept_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_o |-> $past(start_i && !busy_o));

    p_inc_busy_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        inc_o |-> busy_o);

    p_clr_gap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ((clr_o || inc_o) && seen_q && last_clr_q) |-> (since_q > 16'(CLR_CYC)));

    p_step_gap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ((clr_o || inc_o) && seen_q && !last_clr_q) |-> (since_q > 16'(STEP_CYC)));

    p_exclusive_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(clr_o && inc_o));

    p_done_pos_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (seen_q && since_q == need + 16'd1));

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!done_o && !busy_o));

    p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && start_i) |=> !clr_o);

endmodule

bind mpanel_count_drv mpanel_count_drv_chk #(
    .CLK_PS      (CLK_PS),
    .CLR_GAP_PS  (CLR_GAP_PS),
    .STEP_GAP_PS (STEP_GAP_PS)
) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .clr_o   (clr_o),
    .inc_o   (inc_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/mpanel_count_drv_tb_top.sv
module mpanel_count_drv_tb_top;

    localparam int CLK_PS  = 10000;
    localparam int CLR_PS  = 25000;   // rounds up to 3 cycles
    localparam int STEP_PS = 10000;   // exactly 1 cycle
    localparam int VAL_W   = 14;
    localparam int MAXV    = 9999;
    localparam int GC      = (CLR_PS + CLK_PS - 1) / CLK_PS;
    localparam int GI      = (STEP_PS + CLK_PS - 1) / CLK_PS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [VAL_W-1:0] value = '0;
    logic             clr_o, inc_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always #5ns clk = ~clk;

    mpanel_count_drv #(
        .CLK_PS      (CLK_PS),
        .CLR_GAP_PS  (CLR_PS),
        .STEP_GAP_PS (STEP_PS),
        .VAL_W       (VAL_W),
        .MAX_VAL     (MAXV)
    ) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .value_i (value),
        .clr_o   (clr_o),
        .inc_o   (inc_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !ended) begin
            errors++;
            $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cyc, 190000);
            finish_run();
        end
    end

    // One display sequence; optionally pokes a start while busy (R8).
    task automatic run_value(input int v, input bit poke);
        int exp_n, done_at, n_inc, n_clr, overlap, first_inc, bad_step, got_done, i, next_inc;
        string cnt_tag;
        exp_n   = (v > MAXV) ? MAXV : v;
        done_at = GC + 1 + exp_n * (GI + 1);
        cnt_tag = (v == 0) ? "R10" : ((v > MAXV) ? "R9" : "R3");
        while (busy_o) @(negedge clk);
        start = 1'b1;
        value = VAL_W'(v);
        @(negedge clk);
        start = 1'b0;
        check(clr_o == 1'b1 && busy_o == 1'b1 && inc_o == 1'b0, "R2 clear after start", clr_o, 1);
        n_inc = 0; n_clr = 0; overlap = 0; first_inc = -1; bad_step = 0;
        got_done = -1; i = 0; next_inc = GC + 1;
        while (got_done < 0 && i < done_at + 5) begin
            @(negedge clk);
            i++;
            if (poke && (i == 2 || i == done_at - 1)) begin
                start = 1'b1;
                value = VAL_W'(5);
            end else begin
                start = 1'b0;
            end
            if (clr_o && inc_o) overlap++;
            if (clr_o) n_clr++;
            if (inc_o) begin
                n_inc++;
                if (first_inc < 0) first_inc = i;
                else if (i != next_inc) bad_step++;
                next_inc += GI + 1;
            end
            if (done_o) got_done = i;
        end
        start = 1'b0;
        check(n_inc == exp_n, cnt_tag, n_inc, exp_n);
        if (exp_n > 0) check(first_inc == GC + 1, "R4 first increment position", first_inc, GC + 1);
        check(bad_step == 0, "R5 increment spacing", bad_step, 0);
        check(overlap == 0, "R6 overlap", overlap, 0);
        check(n_clr == 0, poke ? "R8 extra clear" : "R2 single clear", n_clr, 0);
        check(got_done == done_at, "R7 done position", got_done, done_at);
        @(negedge clk);
        check(!busy_o && !done_o && !inc_o && !clr_o, "R7 idle after done", busy_o, 0);
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            check(!clr_o && !inc_o && !busy_o && !done_o, "R1 reset state",
                  {clr_o, inc_o, busy_o, done_o}, 0);
        end
        rst = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check(!clr_o && !inc_o && !busy_o && !done_o, "R1 idle without start",
                  {clr_o, inc_o, busy_o, done_o}, 0);
        end
        for (int v = 0; v <= 150; v++) run_value(v, (v % 7) == 3);
        run_value(0, 1'b1);
        run_value(MAXV, 1'b0);
        run_value(10000, 1'b0);
        run_value(16383, 1'b1);
        run_value(1, 1'b0);
        finish_run();
    end

endmodule